// File: doc/BRIEF.md
# Multiprocessor-capable serial frame transmitter

This block turns one parallel character at a time into an asynchronous serial frame. A load strobe hands over a byte together with its frame description. The description is a 3-bit format code that picks the data width, whether parity is sent and how many stop bits follow. It also carries a multiprocessor-mode control. In that mode a tag bit, supplied by software, takes the place of parity. A receiver can use the tag to tell address characters from data characters.

Bit timing comes from an external enable tick. Each serial bit lasts a fixed number of ticks, 16 by default, so the bit rate divider stays outside the block. The busy and empty flags tell the producer when the next character may be loaded. A load strobe that arrives while a frame is in progress is dropped.

Top module: `mpUartTx`

## Requirements
- R1: After reset, and whenever no frame is in progress, serialOut is 1, busy is 0 and txEmpty is 1.
- R2: A loadStb seen while idle starts a frame. From the next cycle, busy is 1, txEmpty is 0 and serialOut is 0 for the start bit.
- R3: Data bits follow the start bit, least significant bit first. fmtCode[2]=1 sends 8 data bits and fmtCode[2]=0 sends bits 6..0 only.
- R4: When mpEnable=0 and fmtCode[1]=1, one parity bit follows the data bits. It is computed over the data bits actually sent. parityOdd=0 makes the count of ones in data plus parity even; parityOdd=1 makes it odd. When fmtCode[1]=0, no bit is inserted.
- R5: The frame ends with stop bits at level 1: two when fmtCode[0]=1 and one when fmtCode[0]=0.
- R6: When mpEnable=1, exactly one tag bit equal to mpBitVal follows the data bits, and no parity bit is sent whatever fmtCode[1] holds.
- R7: Every bit, start and stop bits included, lasts exactly TICKS_PER_BIT cycles with tickEn=1 (default 16). Without tickEn pulses the line does not change.
- R8: txData, fmtCode, mpEnable, mpBitVal and parityOdd are sampled only at an accepted load. Changes during a frame do not alter that frame.
- R9: A loadStb while busy=1 is ignored. This includes the cycle whose tick ends the final stop bit: no new frame follows it.
- R10: busy falls and txEmpty rises in the cycle after the tick that completes the final stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txData | input | 8 | Character to send |
| loadStb | input | 1 | One-cycle request to send txData |
| fmtCode | input | 3 | [2] 8-bit data, [1] parity enable, [0] two stop bits |
| mpEnable | input | 1 | Multiprocessor frame mode |
| mpBitVal | input | 1 | Value of the tag bit in multiprocessor mode |
| parityOdd | input | 1 | 1 selects odd parity, 0 even |
| tickEn | input | 1 | Bit-rate enable tick |
| serialOut | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| txEmpty | output | 1 | Ready for a new character |

## Verification
Two events can fall in the same cycle: a new load strobe and the tick that closes the last stop bit of the current frame. The bench raises loadStb together with that final tick and a changed data byte. It then requires busy to drop and the line to stay high over many further ticks, which shows that the strobe was dropped and no second frame began. Random frames also place stray loads and changed frame inputs in the gaps between ticks. Every bit period is compared against a frame computed in the bench from the values captured at load.

// File: rtl/mpTxPkg.sv
package mpTxPkg;
  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_EXTRA
  } lineSel_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e lineSel;
  } txStb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP
  } txState_e;
endpackage

// File: rtl/mpTxCtrl.sv
module mpTxCtrl
  import mpTxPkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       tickEn,
  input  logic [2:0] fmtCode,
  input  logic       mpEnable,
  output txStb_t     stb,
  output logic       busy
);
  localparam int TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0]  IDX_WIDE  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0]  IDX_NARROW = IDX_W'(DATA_W - 2);

  txState_e          state;
  logic [TICK_W-1:0] tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic              stopIdx;
  logic              wideQ, parEnQ, stop2Q, mpQ;
  logic              accept, bitEnd;
  logic [IDX_W-1:0]  lastIdx;

  assign accept  = loadStb && (state == ST_IDLE);
  assign bitEnd  = tickEn && (state != ST_IDLE) && (tickCnt == TICK_LAST);
  assign lastIdx = wideQ ? IDX_WIDE : IDX_NARROW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      stopIdx <= 1'b0;
      wideQ   <= 1'b0;
      parEnQ  <= 1'b0;
      stop2Q  <= 1'b0;
      mpQ     <= 1'b0;
    end else if (accept) begin
      state   <= ST_START;
      tickCnt <= '0;
      bitIdx  <= '0;
      stopIdx <= 1'b0;
      wideQ   <= fmtCode[2];
      parEnQ  <= fmtCode[1];
      stop2Q  <= fmtCode[0];
      mpQ     <= mpEnable;
    end else if (state != ST_IDLE && tickEn) begin
      tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      if (bitEnd) begin
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            if (bitIdx == lastIdx) state <= (mpQ || parEnQ) ? ST_EXTRA : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end
          ST_EXTRA: state <= ST_STOP;
          ST_STOP: begin
            if (stop2Q && !stopIdx) stopIdx <= 1'b1;
            else state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb.load  = accept;
    stb.shift = bitEnd && (state == ST_DATA);
    case (state)
      ST_START: stb.lineSel = LINE_SPACE;
      ST_DATA:  stb.lineSel = LINE_DATA;
      ST_EXTRA: stb.lineSel = LINE_EXTRA;
      default:  stb.lineSel = LINE_MARK;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(loadStb));

  // R9
  load_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && state != ST_IDLE && state != ST_START) |=> state != ST_START);

  // R7
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !accept) |=> $stable(tickCnt) && $stable(state));

  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(wideQ) && $stable(parEnQ) && $stable(stop2Q) && $stable(mpQ));
endmodule

// File: rtl/mpTxDatapath.sv
module mpTxDatapath
  import mpTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStb_t            stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              fmtWide,
  input  logic              mpEnable,
  input  logic              mpBitVal,
  input  logic              parityOdd,
  output logic              serialOut
);
  localparam logic [DATA_W-1:0] MASK_WIDE   = '1;
  localparam logic [DATA_W-1:0] MASK_NARROW = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] shiftQ;
  logic              extraQ;
  logic [DATA_W-1:0] sentBits;
  logic              parityBit;

  assign sentBits  = txData & (fmtWide ? MASK_WIDE : MASK_NARROW);
  assign parityBit = (^sentBits) ^ parityOdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      extraQ <= 1'b0;
    end else if (stb.load) begin
      shiftQ <= txData;
      extraQ <= mpEnable ? mpBitVal : parityBit;
    end else if (stb.shift) begin
      shiftQ <= {1'b0, shiftQ[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (stb.lineSel)
      LINE_SPACE: serialOut = 1'b0;
      LINE_DATA:  serialOut = shiftQ[0];
      LINE_EXTRA: serialOut = extraQ;
      default:    serialOut = 1'b1;
    endcase
  end

  // R3
  shift_in_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |-> stb.lineSel == LINE_DATA);

  // R8
  extra_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lineSel != LINE_MARK && !stb.load) |=> $stable(extraQ));
endmodule

// File: rtl/mpUartTx.sv
module mpUartTx
  import mpTxPkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              loadStb,
  input  logic [2:0]        fmtCode,
  input  logic              mpEnable,
  input  logic              mpBitVal,
  input  logic              parityOdd,
  input  logic              tickEn,
  output logic              serialOut,
  output logic              busy,
  output logic              txEmpty
);
  txStb_t stb;

  mpTxCtrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .tickEn(tickEn),
    .fmtCode(fmtCode), .mpEnable(mpEnable), .stb(stb), .busy(busy)
  );

  mpTxDatapath #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData), .fmtWide(fmtCode[2]),
    .mpEnable(mpEnable), .mpBitVal(mpBitVal), .parityOdd(parityOdd),
    .serialOut(serialOut)
  );

  assign txEmpty = !busy;

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serialOut);

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(tickEn));
endmodule

// File: tb/mpUartTx_test.sv
`timescale 1ns/1ps
module mpUartTx_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] txData = '0;
  logic       loadStb = 1'b0;
  logic [2:0] fmtCode = '0;
  logic       mpEnable = 1'b0;
  logic       mpBitVal = 1'b0;
  logic       parityOdd = 1'b0;
  logic       tickEn = 1'b0;
  logic       serialOut, busy, txEmpty;

  int checks = 0;
  int failures = 0;
  logic expBits [0:11];
  string expTag [0:11];
  int nBits;

  always #2.5 clk = ~clk;

  mpUartTx uut (
    .clk(clk), .rstN(rstN), .txData(txData), .loadStb(loadStb), .fmtCode(fmtCode),
    .mpEnable(mpEnable), .mpBitVal(mpBitVal), .parityOdd(parityOdd), .tickEn(tickEn),
    .serialOut(serialOut), .busy(busy), .txEmpty(txEmpty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic parityOf(input logic [7:0] d, input logic wide, input logic odd);
    logic [7:0] m;
    m = wide ? d : {1'b0, d[6:0]};
    return (^m) ^ odd;
  endfunction

  task automatic buildFrame(input logic [7:0] d, input logic [2:0] f, input logic mp,
                            input logic mpb, input logic odd);
    int n;
    int k;
    n = f[2] ? 8 : 7;
    expBits[0] = 1'b0; expTag[0] = "R2";
    k = 1;
    for (int i = 0; i < n; i++) begin
      expBits[k] = d[i]; expTag[k] = "R3"; k++;
    end
    if (mp) begin
      expBits[k] = mpb; expTag[k] = "R6"; k++;
    end else if (f[1]) begin
      expBits[k] = parityOf(d, f[2], odd); expTag[k] = "R4"; k++;
    end
    for (int i = 0; i < (f[0] ? 2 : 1); i++) begin
      expBits[k] = 1'b1; expTag[k] = "R5"; k++;
    end
    nBits = k;
  endtask

  task automatic runFrame(input logic [7:0] d, input logic [2:0] f, input logic mp,
                          input logic mpb, input logic odd, input bit noisy,
                          input bit edgeLoad, input bit stall);
    buildFrame(d, f, mp, mpb, odd);
    @(negedge clk);
    txData = d; fmtCode = f; mpEnable = mp; mpBitVal = mpb; parityOdd = odd;
    loadStb = 1'b1; tickEn = 1'b0;
    @(negedge clk);
    loadStb = 1'b0;
    check(busy === 1'b1 && txEmpty === 1'b0, "R2 busy after load", busy, 1);
    if (stall) begin
      bit ok = 1;
      for (int c = 0; c < 50; c++) begin
        if (serialOut !== 1'b0 || busy !== 1'b1) ok = 0;
        @(negedge clk);
      end
      check(ok, "R7 no ticks line held", serialOut, 0);
    end
    for (int b = 0; b < nBits; b++) begin
      bit ok = 1;
      int badVal = 0;
      for (int t = 0; t < 16; t++) begin
        int gaps = noisy ? int'($urandom % 3) : 0;
        for (int g = 0; g < gaps; g++) begin
          if (serialOut !== expBits[b]) begin ok = 0; badVal = serialOut; end
          txData = 8'($urandom); fmtCode = 3'($urandom); mpEnable = 1'($urandom);
          mpBitVal = 1'($urandom); parityOdd = 1'($urandom);
          loadStb = 1'($urandom);
          @(negedge clk);
          loadStb = 1'b0;
        end
        if (serialOut !== expBits[b]) begin ok = 0; badVal = serialOut; end
        tickEn = 1'b1;
        if (edgeLoad && b == nBits - 1 && t == 15) begin
          loadStb = 1'b1; txData = ~d;
        end
        @(negedge clk);
        tickEn = 1'b0; loadStb = 1'b0;
      end
      check(ok, $sformatf("%s bit %0d of frame", expTag[b], b), badVal, expBits[b]);
    end
    check(busy === 1'b0 && txEmpty === 1'b1 && serialOut === 1'b1,
          "R10 busy drops after last stop", busy, 0);
    if (edgeLoad) begin
      bit ok = 1;
      for (int c = 0; c < 40; c++) begin
        tickEn = 1'b1;
        if (serialOut !== 1'b1 || busy !== 1'b0) ok = 0;
        @(negedge clk);
      end
      tickEn = 1'b0;
      check(ok, "R9 load on final tick dropped", serialOut, 1);
      check(serialOut === 1'b1 && txEmpty === 1'b1, "R1 idle between frames", serialOut, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(serialOut === 1'b1 && busy === 1'b0 && txEmpty === 1'b1, "R1 reset state", serialOut, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(serialOut === 1'b1 && busy === 1'b0 && txEmpty === 1'b1, "R1 after reset release", busy, 0);

    for (int f = 0; f < 8; f++)
      runFrame(8'hA5 ^ 8'(f * 37), 3'(f), 1'b0, 1'b0, 1'(f >> 1), 1'b0, 1'b0, 1'b0);
    runFrame(8'hFF, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    runFrame(8'h80, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runFrame(8'h3C, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    runFrame(8'h3C, 3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    runFrame(8'h5A, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    runFrame(8'hC3, 3'b111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    runFrame(8'h01, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++)
      runFrame(8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               1'b1, 1'(i % 4 == 0), 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule